// File: doc/BRIEF.md
# Command/Response FIFO Handshake Controller

This block is the device-side state machine behind a byte-wide register window through which a host sends a command to a secure module and reads back its answer. The host writes command bytes one at a time into a data-FIFO register. The block reads the big-endian length carried in the command header and raises a "more data wanted" flag until that many bytes have arrived. It also publishes a 16-bit burst count, so the host knows how many bytes it may move before it has to poll again.

When the host writes the go bit after a complete command, a stub executor holds the interface busy for a fixed number of cycles. It then fills a 16-byte response buffer with a fixed response, and the host drains it through the same FIFO register. Writing the command-ready bit at any time abandons the current transaction and leaves the interface ready for a new command. Locality arbitration and real command execution belong to other blocks.

Top module: `cmd_fifo_handshake`

## Requirements
- R1: After reset the interface is idle. The status byte reads 0x80 (only the valid flag set), both burst-count bytes read 0x00, and a FIFO read returns 0xFF.
- R2: Register offsets within the window are: 0x18 status, 0x19 burst count low byte, 0x1A burst count high byte, 0x24 data FIFO. Other offsets read 0x00. Status bits are: 7 valid, 6 command ready, 5 go (always reads 0), 4 data available, 3 data expected. Bits 2..0 read 0.
- R3: A status write with bit 6 set aborts whatever is in progress, from any state. It clears the command and response buffers and all counters, and puts the interface in the ready state (status 0xC0) on the next cycle. When bit 5 is set in the same write, the abort still wins.
- R4: In the ready state the first FIFO byte moves the interface to receiving. The expected total is 10 header bytes until header byte 5 arrives. From then on it is the big-endian 32-bit value in header bytes 2..5, raised to 10 if smaller. Data expected is 1 while receiving and bytes are still owed, and it reads 0 once the final byte is in.
- R5: While ready or receiving, the burst count is the smaller of the free space in a 16-byte command buffer and the number of bytes still owed. The buffer hands one byte per clock to the executor.
- R6: A go write while receiving with no bytes owed starts execution. The interface then shows valid = 0 for EXEC_CYCLES cycles. A go write in any other situation is ignored.
- R7: After execution the response buffer fills one byte per clock, and data available rises together with valid. The response is RESP_LEN bytes. Bytes 0 and 1 are 0x00 and 0xC4. Bytes 2..5 hold RESP_LEN in big-endian order. Bytes 6..9 repeat command bytes 6..9. Byte k ≥ 10 is the low byte of 3k + 0x11. While completing, the burst count equals the number of buffered response bytes.
- R8: Data available stays 1 until a read or an abort. It falls to 0 after the host reads the last response byte.
- R9: FIFO writes outside the ready and receiving states, or when no bytes are owed, change nothing. FIFO reads with data available at 0 return 0xFF and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a FIFO read pops one byte |
| addr | input | ADDR_W | Byte offset within the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as rd_en; 0 when rd_en is low |

## Verification
The bound checker watches several properties on every cycle:
- an abort always lands in the ready state;
- the burst count never exceeds the buffer depth, and it is zero once a command is complete;
- data available never appears without valid, and it holds until a read or abort;
- an empty FIFO read returns 0xFF;
- execution only ever proceeds to completion.

Only the bench scenarios can show the rest: that the length field is assembled in big-endian order, the exact response byte values and their order, that the execution delay lasts the right number of cycles, and that the burst count steps between 15 and 16 as the command buffer drains.

// File: rtl/cmdif_pkg.sv
`timescale 1ns/1ps
package cmdif_pkg;

    localparam int HDR_BYTES  = 10;
    localparam int LEN_FIRST  = 2;
    localparam int LEN_LAST   = 5;
    localparam int CODE_FIRST = 6;
    localparam int CODE_LAST  = 9;

    localparam int OFF_STS      = 'h18;
    localparam int OFF_BURST_LO = 'h19;
    localparam int OFF_BURST_HI = 'h1A;
    localparam int OFF_FIFO     = 'h24;

    localparam logic [7:0] EMPTY_BYTE  = 8'hFF;
    localparam logic [7:0] RESP_TAG_HI = 8'h00;
    localparam logic [7:0] RESP_TAG_LO = 8'hC4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY,
        ST_RECV,
        ST_EXEC,
        ST_DONE
    } if_state_e;

    typedef struct packed {
        logic       valid;
        logic       rdy;
        logic       go;
        logic       avail;
        logic       more;
        logic [2:0] rsvd;
    } sts_byte_t;

    // Smaller of two counts, clipped to the 16-bit burst field
    function automatic logic [15:0] burst_of(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a[15:0] : b[15:0];
    endfunction

    // Fixed response produced by the executor stub
    function automatic logic [7:0] resp_byte(input logic [31:0] idx,
                                             input logic [31:0] len,
                                             input logic [31:0] code);
        logic [7:0] b;
        case (idx)
            32'd0:   b = RESP_TAG_HI;
            32'd1:   b = RESP_TAG_LO;
            32'd2:   b = len[31:24];
            32'd3:   b = len[23:16];
            32'd4:   b = len[15:8];
            32'd5:   b = len[7:0];
            32'd6:   b = code[31:24];
            32'd7:   b = code[23:16];
            32'd8:   b = code[15:8];
            32'd9:   b = code[7:0];
            default: b = idx[7:0] * 8'd3 + 8'h11;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cmdif_byte_fifo.sv
`timescale 1ns/1ps
module cmdif_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign do_push = push && (count < CW'(DEPTH));
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/cmdif_hdr_track.sv
`timescale 1ns/1ps
module cmdif_hdr_track
    import cmdif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        take,
    input  logic [7:0]  din,
    output logic [31:0] owed
);

    logic [31:0] rcvd;
    logic [31:0] total;
    logic [23:0] len_acc;
    logic [31:0] len_next;
    logic        in_len;

    assign len_next = {len_acc, din};
    assign in_len   = (rcvd >= 32'(LEN_FIRST)) && (rcvd <= 32'(LEN_LAST));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rcvd    <= '0;
            total   <= 32'(HDR_BYTES);
            len_acc <= '0;
        end else if (take) begin
            rcvd <= rcvd + 32'd1;
            if (in_len) len_acc <= len_next[23:0];
            if (rcvd == 32'(LEN_LAST))
                total <= (len_next < 32'(HDR_BYTES)) ? 32'(HDR_BYTES) : len_next;
        end
    end

    assign owed = total - rcvd;

endmodule

// File: rtl/cmdif_resp_stub.sv
`timescale 1ns/1ps
module cmdif_resp_stub
    import cmdif_pkg::*;
#(
    parameter int EXEC_CYCLES = 5,
    parameter int RESP_LEN    = 14,
    localparam int TW         = $clog2(EXEC_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic       fill_en,
    input  logic       drain,
    input  logic [7:0] drain_byte,
    output logic       done,
    output logic       gen_left,
    output logic       started,
    output logic [7:0] gen_byte
);

    logic [TW-1:0] tmr;
    logic [31:0]   produced;
    logic [3:0]    dcnt;
    logic [31:0]   code;
    logic          in_code;

    // execution delay
    always_ff @(posedge clk) begin
        if (rst || clr || !run) tmr <= '0;
        else if (!done)         tmr <= tmr + TW'(1);
    end
    assign done = run && (tmr == TW'(EXEC_CYCLES - 1));

    // command sink: keeps the code bytes for the echo
    assign in_code = (dcnt >= 4'(CODE_FIRST)) && (dcnt <= 4'(CODE_LAST));
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            dcnt <= '0;
            code <= '0;
        end else if (drain) begin
            if (dcnt != 4'(HDR_BYTES)) dcnt <= dcnt + 4'd1;
            if (in_code) code <= {code[23:0], drain_byte};
        end
    end

    // response generator
    always_ff @(posedge clk) begin
        if (rst || clr || run)        produced <= '0;
        else if (fill_en && gen_left) produced <= produced + 32'd1;
    end

    assign gen_left = produced < 32'(RESP_LEN);
    assign started  = produced != '0;
    assign gen_byte = resp_byte(produced, 32'(RESP_LEN), code);

endmodule

// File: rtl/cmd_fifo_handshake.sv
`timescale 1ns/1ps
module cmd_fifo_handshake
    import cmdif_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int BUF_DEPTH   = 16,
    parameter int EXEC_CYCLES = 5,
    parameter int RESP_LEN    = 14,
    localparam int CW         = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    if_state_e   state;
    if_state_e   state_nx;
    logic        sel_sts, sel_blo, sel_bhi, sel_fifo;
    logic        abort, go_req, accept;
    logic        resp_pop, fill_en, resp_push;
    logic [31:0] owed;
    logic [31:0] cmd_free;
    logic [CW-1:0] cmd_cnt;
    logic [CW-1:0] resp_cnt;
    logic [7:0]  cmd_dout, resp_dout, gen_byte;
    logic        cmd_drain;
    logic        exec_done, gen_left, started;
    logic [15:0] burst;
    logic        avail, sts_valid, more;
    sts_byte_t   sts;

    // address decode
    assign sel_sts  = addr == ADDR_W'(OFF_STS);
    assign sel_blo  = addr == ADDR_W'(OFF_BURST_LO);
    assign sel_bhi  = addr == ADDR_W'(OFF_BURST_HI);
    assign sel_fifo = addr == ADDR_W'(OFF_FIFO);

    assign abort  = wr_en && sel_sts && wdata[6];
    assign go_req = wr_en && sel_sts && wdata[5] && !wdata[6];

    assign cmd_free = 32'(BUF_DEPTH) - 32'(cmd_cnt);
    assign accept   = wr_en && sel_fifo && (state == ST_READY || state == ST_RECV)
                      && (owed != '0) && (cmd_free != '0);
    assign cmd_drain = cmd_cnt != '0;

    assign avail     = (state == ST_DONE) && (resp_cnt != '0);
    assign sts_valid = !(state == ST_EXEC || (state == ST_DONE && !started));
    assign more      = (state == ST_RECV) && (owed != '0);

    assign resp_pop  = rd_en && sel_fifo && avail;
    assign fill_en   = (state == ST_DONE) && (resp_cnt < CW'(BUF_DEPTH));
    assign resp_push = fill_en && gen_left;

    // state sequence
    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = ST_READY;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_READY: if (accept) state_nx = ST_RECV;
                ST_RECV:  if (go_req && owed == '0) state_nx = ST_EXEC;
                ST_EXEC:  if (exec_done) state_nx = ST_DONE;
                ST_DONE:  state_nx = ST_DONE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    cmdif_hdr_track u_hdr (
        .clk  (clk),
        .rst  (rst),
        .clr  (abort),
        .take (accept),
        .din  (wdata),
        .owed (owed)
    );

    cmdif_byte_fifo #(.DEPTH(BUF_DEPTH), .W(8)) u_cmd_buf (
        .clk   (clk),
        .rst   (rst),
        .clr   (abort),
        .push  (accept),
        .pop   (cmd_drain),
        .din   (wdata),
        .dout  (cmd_dout),
        .count (cmd_cnt)
    );

    cmdif_resp_stub #(.EXEC_CYCLES(EXEC_CYCLES), .RESP_LEN(RESP_LEN)) u_exec (
        .clk        (clk),
        .rst        (rst),
        .clr        (abort),
        .run        (state == ST_EXEC),
        .fill_en    (fill_en),
        .drain      (cmd_drain),
        .drain_byte (cmd_dout),
        .done       (exec_done),
        .gen_left   (gen_left),
        .started    (started),
        .gen_byte   (gen_byte)
    );

    cmdif_byte_fifo #(.DEPTH(BUF_DEPTH), .W(8)) u_resp_buf (
        .clk   (clk),
        .rst   (rst),
        .clr   (abort),
        .push  (resp_push),
        .pop   (resp_pop),
        .din   (gen_byte),
        .dout  (resp_dout),
        .count (resp_cnt)
    );

    // burst count
    always_comb begin
        unique case (state)
            ST_READY, ST_RECV: burst = burst_of(cmd_free, owed);
            ST_DONE:           burst = 16'(resp_cnt);
            default:           burst = '0;
        endcase
    end

    always_comb begin
        sts       = '0;
        sts.valid = sts_valid;
        sts.rdy   = state == ST_READY;
        sts.go    = 1'b0;
        sts.avail = avail;
        sts.more  = more;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_sts)       rdata = sts;
            else if (sel_blo)  rdata = burst[7:0];
            else if (sel_bhi)  rdata = burst[15:8];
            else if (sel_fifo) rdata = avail ? resp_dout : EMPTY_BYTE;
        end
    end

endmodule

// File: rtl/cmd_fifo_handshake_chk.sv
`timescale 1ns/1ps
module cmd_fifo_handshake_chk
    import cmdif_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BUF_DEPTH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              abort_bit,
    input logic [7:0]        rdata,
    input if_state_e         state,
    input logic [31:0]       owed,
    input logic [15:0]       burst,
    input logic              avail,
    input logic              sts_valid
);

    logic hit_sts, hit_fifo, abort_w;

    assign hit_sts  = addr == ADDR_W'(OFF_STS);
    assign hit_fifo = addr == ADDR_W'(OFF_FIFO);
    assign abort_w  = wr_en && hit_sts && abort_bit;

    // R3
    abort_to_ready_chk: assert property (@(posedge clk) disable iff (rst)
        abort_w |=> state == ST_READY);

    // R5
    burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
        burst <= 16'(BUF_DEPTH));

    // R4
    full_cmd_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV && owed == '0) |-> burst == 16'd0);

    // R6
    exec_path_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && !abort_w) |=> (state == ST_EXEC || state == ST_DONE));

    // R7
    avail_valid_chk: assert property (@(posedge clk) disable iff (rst)
        avail |-> sts_valid);

    // R8
    avail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (avail && !(rd_en && hit_fifo) && !abort_w) |=> avail);

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hit_fifo && !avail) |-> rdata == 8'hFF);

endmodule

bind cmd_fifo_handshake cmd_fifo_handshake_chk #(
    .ADDR_W    (ADDR_W),
    .BUF_DEPTH (BUF_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .abort_bit (wdata[6]),
    .rdata     (rdata),
    .state     (state),
    .owed      (owed),
    .burst     (burst),
    .avail     (avail),
    .sts_valid (sts_valid)
);

// File: tb/sim_cmd_fifo_handshake.sv
`timescale 1ns/1ps
module sim_cmd_fifo_handshake;

    localparam int DEPTH  = 16;
    localparam int EXEC_N = 5;
    localparam int RSP_N  = 14;
    localparam int A_STS  = 'h18;
    localparam int A_BLO  = 'h19;
    localparam int A_BHI  = 'h1A;
    localparam int A_FIFO = 'h24;
    localparam int WDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    always #2 clk = ~clk;

    cmd_fifo_handshake u0 (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model: 0 idle, 1 ready, 2 receiving, 3 executing, 4 completing
    int          m_st;
    int          m_occ;
    longint      m_rcvd;
    longint      m_total;
    logic [31:0] m_len;
    logic [31:0] m_code;
    int          m_tmr;
    int          m_prod;
    logic [7:0]  m_rq[$];

    task automatic m_clear();
        m_occ = 0; m_rcvd = 0; m_total = 10; m_len = '0; m_code = '0;
        m_tmr = 0; m_prod = 0; m_rq.delete();
    endtask

    function automatic longint m_owed();
        return m_total - m_rcvd;
    endfunction

    function automatic int m_burst();
        longint f = DEPTH - m_occ;
        longint o = m_owed();
        if (m_st == 1 || m_st == 2) return int'((f < o) ? f : o);
        if (m_st == 4) return m_rq.size();
        return 0;
    endfunction

    function automatic logic [7:0] m_status();
        logic v = !(m_st == 3 || (m_st == 4 && m_prod == 0));
        logic av = (m_st == 4) && (m_rq.size() > 0);
        logic mo = (m_st == 2) && (m_owed() > 0);
        return {v, (m_st == 1), 1'b0, av, mo, 3'b000};
    endfunction

    function automatic logic [7:0] m_rsp(int k);
        logic [31:0] n = RSP_N;
        if (k == 0) return 8'h00;
        if (k == 1) return 8'hC4;
        if (k >= 2 && k <= 5) return n[8*(5-k) +: 8];
        if (k >= 6 && k <= 9) return m_code[8*(9-k) +: 8];
        return 8'((k * 3 + 'h11) & 'hFF);
    endfunction

    function automatic logic [7:0] m_read(int a);
        int b = m_burst();
        if (a == A_STS)  return m_status();
        if (a == A_BLO)  return 8'(b & 'hFF);
        if (a == A_BHI)  return 8'((b >> 8) & 'hFF);
        if (a == A_FIFO) return (m_st == 4 && m_rq.size() > 0) ? m_rq[0] : 8'hFF;
        return 8'h00;
    endfunction

    task automatic m_step(bit we, bit re, int a, logic [7:0] d);
        longint owed = m_owed();
        int     freeb = DEPTH - m_occ;
        bit     acc, popc, popr, pushr;
        if (we && a == A_STS && d[6]) begin
            m_clear();
            m_st = 1;
            return;
        end
        acc  = we && a == A_FIFO && (m_st == 1 || m_st == 2) && owed > 0 && freeb > 0;
        popc = m_occ > 0;
        m_occ = m_occ + int'(acc) - int'(popc);
        if (acc) begin
            if (m_rcvd >= 2 && m_rcvd <= 5) m_len = {m_len[23:0], d};
            if (m_rcvd == 5) m_total = (m_len < 10) ? 10 : longint'(m_len);
            if (m_rcvd >= 6 && m_rcvd <= 9) m_code = {m_code[23:0], d};
            m_rcvd++;
            m_st = 2;
        end else if (we && a == A_STS && d[5] && m_st == 2 && owed == 0) begin
            m_st = 3; m_tmr = 0; m_prod = 0;
        end else if (m_st == 3) begin
            if (m_tmr == EXEC_N - 1) m_st = 4;
            else m_tmr++;
        end else if (m_st == 4) begin
            popr  = re && a == A_FIFO && m_rq.size() > 0;
            pushr = m_prod < RSP_N && m_rq.size() < DEPTH;
            if (popr) void'(m_rq.pop_front());
            if (pushr) begin
                m_rq.push_back(m_rsp(m_prod));
                m_prod++;
            end
        end
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(bit we, bit re, int a, logic [7:0] d, string req);
        @(negedge clk);
        wr_en = we; rd_en = re; addr = 12'(a); wdata = d;
        #1;
        if (re) check(req, rdata, m_read(a));
        @(posedge clk);
        m_step(we, re, a, d);
    endtask

    task automatic wr(int a, logic [7:0] d, string req);
        step(1'b1, 1'b0, a, d, req);
    endtask

    task automatic rd(int a, string req);
        step(1'b0, 1'b1, a, 8'h00, req);
    endtask

    task automatic send(logic [31:0] len, logic [31:0] code, int from, int upto, string req);
        for (int i = from; i < upto; i++) begin
            logic [7:0] b;
            if (i == 0) b = 8'h00;
            else if (i == 1) b = 8'hC1;
            else if (i <= 5) b = len[8*(5-i) +: 8];
            else if (i <= 9) b = code[8*(9-i) +: 8];
            else b = 8'(8'h40 + i);
            wr(A_FIFO, b, req);
        end
    endtask

    task automatic wait_avail(string req);
        for (int i = 0; i < 40; i++) begin
            rd(A_STS, req);
            if (m_st == 4 && m_rq.size() > 0) break;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected<%0d", cyc, WDOG);
            finish_run();
        end
    end

    initial begin
        m_clear();
        m_st = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset view
        rd(A_STS, "R1");
        rd(A_BLO, "R1");
        rd(A_BHI, "R1");
        rd(A_FIFO, "R1");
        rd('h30, "R2");

        // R9 FIFO write while idle, R6 go while idle
        wr(A_FIFO, 8'h11, "R9");
        rd(A_STS, "R9");
        wr(A_STS, 8'h20, "R6");
        rd(A_STS, "R6");

        // R3 leave idle, R2 status layout, R5 initial burst
        wr(A_STS, 8'h40, "R3");
        rd(A_STS, "R2");
        rd(A_BLO, "R5");
        rd(A_BHI, "R5");

        // R4 twelve-byte command
        send(32'd12, 32'h0000007B, 0, 3, "R4");
        rd(A_STS, "R4");
        rd(A_BLO, "R5");
        send(32'd12, 32'h0000007B, 3, 8, "R4");
        wr(A_STS, 8'h20, "R6");
        rd(A_STS, "R6");
        send(32'd12, 32'h0000007B, 8, 12, "R4");
        rd(A_STS, "R4");
        rd(A_BLO, "R4");
        wr(A_FIFO, 8'hEE, "R9");
        rd(A_BLO, "R9");
        rd(A_STS, "R9");

        // R6 execute, R7 response, R8 drain
        wr(A_STS, 8'h20, "R6");
        rd(A_STS, "R6");
        wr(A_FIFO, 8'h99, "R9");
        wait_avail("R7");
        rd(A_BLO, "R7");
        for (int i = 0; i < RSP_N; i++) rd(A_FIFO, "R7");
        rd(A_STS, "R8");
        rd(A_FIFO, "R9");
        rd(A_BLO, "R8");

        // R4 short length raised to header size, R3 abort beats go
        wr(A_STS, 8'h40, "R3");
        send(32'd4, 32'h1234ABCD, 0, 9, "R4");
        rd(A_STS, "R4");
        send(32'd4, 32'h1234ABCD, 9, 10, "R4");
        rd(A_STS, "R4");
        wr(A_STS, 8'h60, "R3");
        rd(A_STS, "R3");

        // R5 burst against buffer space, R3 abort while receiving
        send(32'h30, 32'hCAFE0001, 0, 7, "R5");
        rd(A_BLO, "R5");
        rd(A_BLO, "R5");
        rd(A_BHI, "R5");
        wr(A_STS, 8'h40, "R3");
        rd(A_STS, "R3");
        rd(A_BLO, "R3");

        // R3 abort during execution
        send(32'd10, 32'h01020304, 0, 10, "R6");
        wr(A_STS, 8'h20, "R6");
        rd(A_STS, "R6");
        wr(A_STS, 8'h40, "R3");
        rd(A_STS, "R3");

        // R7 back-to-back reads while the buffer fills
        send(32'd11, 32'hA5B6C7D8, 0, 11, "R4");
        wr(A_STS, 8'h20, "R6");
        wait_avail("R7");
        for (int i = 0; i < 4; i++) rd(A_FIFO, "R7");
        rd(A_BLO, "R7");
        for (int i = 4; i < RSP_N; i++) rd(A_FIFO, "R7");
        rd(A_STS, "R8");
        rd(A_FIFO, "R8");

        finish_run();
    end

endmodule